// File: doc/BRIEF.md
# Clocked Serial Transmitter with Byte Queue

This block sends bytes from a host over a clock-synchronous serial link. The host writes bytes into a 16-entry queue. The block moves the head byte into a shift register and drives it out on a single data line, least significant bit first. A serial clock runs alongside the data. The block can make that clock itself with a divider, or follow a clock supplied from outside. The data changes on the falling clock edge, so the receiver samples on the rising edge.

Frames run back to back with no gap. While the last bit of a frame is on the line, the block looks at the queue. If a byte is waiting, it is loaded at once and the next frame follows directly. If the queue is empty, the block raises a transmit-end flag, keeps the data line at the level of the last bit, and parks the serial clock high.

A queue-low flag tracks the fill level against a selectable threshold and drives an interrupt request when enabled. A write that finds the queue full is dropped, and a sticky overflow flag records it.

Top module: `sync_serial_tx`

## Requirements
- R1: With the internal clock, bytes that are queued in time go out back to back. Successive rising serial-clock edges are exactly 2*HALF_DIV cycles apart, including across frame boundaries.
- R2: Each frame is 8 rising serial-clock edges long. On those edges the receiver sees bit 0 through bit 7 of the byte, in that order. `txd` changes only in the cycle after a falling-edge event of the serial clock.
- R3: `fifo_low` is 1 in the cycle after the queue level is at or below the threshold. The threshold is 1, 2, 4 or 8 for `trig_sel` = 0, 1, 2 or 3.
- R4: A pulse on `low_clr` clears `fifo_low` one cycle later, but only when the queue level is above the threshold. Otherwise the flag stays 1.
- R5: `tx_irq` is the registered AND of the next `fifo_low` value and `tx_irq_en`. `tx_irq` is never 1 while `fifo_low` is 0.
- R6: When the queue is empty at the last-bit check, `tx_end` goes to 1. After the frame, `txd` holds the level of bit 7. While the block is idle, `txd` does not change.
- R7: An accepted write clears `tx_end` in the following cycle. Only an accepted write clears it.
- R8: When no frame is in progress, `sclk_out` is 1.
- R9: When `ext_clk_sel` is 1, `ext_clk_in` paces the bits through a two-stage synchronizer. Each falling edge of the input advances one bit, and `sclk_out` follows the synchronized input while a frame is active.
- R10: A write while the queue holds DEPTH bytes is dropped, and the level stays at DEPTH. `overflow` then goes to 1 and stays at 1 until reset.
- R11: After reset, `txd`=1, `sclk_out`=1, `fifo_level`=0, `fifo_low`=1, `tx_end`=1, `tx_irq`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | DATA_W | Byte to queue |
| trig_sel | input | 2 | Threshold select: 1, 2, 4 or 8 bytes |
| low_clr | input | 1 | Request to clear the queue-low flag |
| tx_irq_en | input | 1 | Interrupt enable |
| ext_clk_sel | input | 1 | 1 selects the external serial clock |
| ext_clk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Serial clock output |
| txd | output | 1 | Serial data output |
| fifo_level | output | CNT_W | Bytes held in the queue |
| fifo_low | output | 1 | Queue at or below threshold |
| tx_end | output | 1 | Transmission finished, queue empty |
| tx_irq | output | 1 | Interrupt request |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions take for granted that `ext_clk_in` rests high whenever a frame begins in external mode. They also assume each level of that clock lasts longer than the synchronizer, and that `ext_clk_sel` changes only while the block is idle. The stimulus keeps to this: the bench holds the external clock high between bursts, and every external half-period lasts three or more system cycles. It switches the mode only after `tx_end` is set and the clock has returned high.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam int TRIG_W = 2;

  // Threshold in bytes for the select code: 1, 2, 4, 8
  function automatic int unsigned trig_level(input logic [TRIG_W-1:0] sel);
    return 32'd1 << sel;
  endfunction
endpackage

// File: rtl/sstx_fifo.sv
module sstx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sstx_clkgen.sv
module sstx_clkgen #(
  parameter int HALF_DIV = 4,
  localparam int HW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic ext_in,
  input  logic run,
  output logic sclk,
  output logic fall,
  output logic rise
);
  logic          s1, s2, s3;
  logic [HW-1:0] div_cnt;
  logic          wrap;

  generate
    if (HALF_DIV > 1) begin : g_div
      assign wrap = (div_cnt == HW'(HALF_DIV - 1));
    end else begin : g_nodiv
      assign wrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    if (ext_sel) begin
      fall = run & s3 & ~s2;
      rise = run & ~s3 & s2;
    end else begin
      fall = run & wrap & sclk;
      rise = run & wrap & ~sclk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sclk    <= 1'b1;
    end else if (!run) begin
      div_cnt <= '0;
      sclk    <= 1'b1;
    end else if (ext_sel) begin
      div_cnt <= '0;
      sclk    <= s2;
    end else if (wrap) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // R9
  ext_edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fall && rise));
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
  parameter int DW  = 8,
  localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          rise,
  input  logic          q_empty,
  input  logic [DW-1:0] q_data,
  output logic          pop,
  output logic          busy,
  output logic          txd,
  output logic          end_set
);
  logic [DW-1:0] shreg;
  logic [IW-1:0] bit_idx;
  logic          stop_q;
  logic          start, last;

  assign start   = ~busy & ~q_empty;
  assign last    = busy & fall & ~stop_q & (bit_idx == IW'(DW - 1));
  assign pop     = start | (last & ~q_empty);
  assign end_set = last & q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_idx <= '0;
      busy    <= 1'b0;
      stop_q  <= 1'b0;
      txd     <= 1'b1;
    end else if (start) begin
      shreg   <= q_data;
      bit_idx <= '0;
      busy    <= 1'b1;
      stop_q  <= 1'b0;
    end else if (busy) begin
      if (fall && !stop_q) begin
        txd <= shreg[bit_idx];
        if (last) begin
          bit_idx <= '0;
          if (!q_empty) shreg  <= q_data;
          else          stop_q <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
      if (rise && stop_q) begin
        busy   <= 1'b0;
        stop_q <= 1'b0;
      end
    end
  end

  // R2
  txd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(fall));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(txd));
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
  import sstx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TRIG_W-1:0] trig_sel,
  input  logic              low_clr,
  input  logic              tx_irq_en,
  input  logic              ext_clk_sel,
  input  logic              ext_clk_in,
  output logic              sclk_out,
  output logic              txd,
  output logic [CNT_W-1:0]  fifo_level,
  output logic              fifo_low,
  output logic              tx_end,
  output logic              tx_irq,
  output logic              overflow
);
  logic [DATA_W-1:0] q_data;
  logic              q_full, q_empty, q_pop;
  logic              busy, fall, rise, end_set;
  logic              wr_ok, low_nxt;
  logic [CNT_W-1:0]  lvl;

  assign lvl   = CNT_W'(trig_level(trig_sel));
  assign wr_ok = wr_en & ~q_full;

  sstx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(q_pop),
    .dout(q_data), .count(fifo_level), .full(q_full), .empty(q_empty)
  );

  sstx_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk(clk), .rst(rst), .ext_sel(ext_clk_sel), .ext_in(ext_clk_in),
    .run(busy), .sclk(sclk_out), .fall(fall), .rise(rise)
  );

  sstx_shifter #(.DW(DATA_W)) i_shift (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise), .q_empty(q_empty),
    .q_data(q_data), .pop(q_pop), .busy(busy), .txd(txd), .end_set(end_set)
  );

  always_comb begin
    if (fifo_level <= lvl) low_nxt = 1'b1;
    else if (low_clr)      low_nxt = 1'b0;
    else                   low_nxt = fifo_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_low <= 1'b1;
      tx_irq   <= 1'b0;
      tx_end   <= 1'b1;
      overflow <= 1'b0;
    end else begin
      fifo_low <= low_nxt;
      tx_irq   <= low_nxt & tx_irq_en;
      if (wr_ok)        tx_end <= 1'b0;
      else if (end_set) tx_end <= 1'b1;
      if (wr_en && q_full) overflow <= 1'b1;
    end
  end

  // R8
  idle_sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_out);

  // R5
  irq_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> fifo_low);

  // R3
  low_at_level_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_level <= lvl) |=> fifo_low);

  // R7
  end_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_end && !wr_en) |=> tx_end);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: tb/test_sync_serial_tx.sv
module test_sync_serial_tx;
  localparam int HALF = 2;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] trig_sel = '0;
  logic low_clr = 1'b0;
  logic tx_irq_en = 1'b0;
  logic ext_clk_sel = 1'b0;
  logic ext_clk_in = 1'b1;
  logic sclk_out, txd, fifo_low, tx_end, tx_irq, overflow;
  logic [CW-1:0] fifo_level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  int rise_cnt = 0, first_rise = 0, last_rise = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_serial_tx #(.DATA_W(8), .DEPTH(DEPTH), .HALF_DIV(HALF)) i_sync_serial_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .trig_sel(trig_sel),
    .low_clr(low_clr), .tx_irq_en(tx_irq_en), .ext_clk_sel(ext_clk_sel),
    .ext_clk_in(ext_clk_in), .sclk_out(sclk_out), .txd(txd),
    .fifo_level(fifo_level), .fifo_low(fifo_low), .tx_end(tx_end),
    .tx_irq(tx_irq), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: receiver sampling on rising serial clock, scoreboard compare (R2)
  logic sclk_prev = 1'b1;
  logic [7:0] shin = '0;
  int nbits = 0;
  always @(negedge clk) begin
    if (rst) begin
      sclk_prev = 1'b1;
      nbits = 0;
    end else begin
      if (sclk_out && !sclk_prev) begin
        shin = {txd, shin[7:1]};
        nbits++;
        if (rise_cnt == 0) first_rise = cyc;
        last_rise = cyc;
        rise_cnt++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected frame", shin, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(shin == e, "R2 frame byte", shin, e);
          end
        end
      end
      sclk_prev = sclk_out;
    end
  end

  task automatic put(input logic [7:0] b, input bit accepted);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    if (accepted) exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    low_clr = 1'b1;
    @(negedge clk);
    low_clr = 1'b0;
  endtask

  task automatic ext_pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b0;
      repeat (half) @(negedge clk);
      ext_clk_in = 1'b1;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_end && sclk_out && fifo_level == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11 txd", txd, 1);
    chk(sclk_out == 1'b1, "R8 sclk idle", sclk_out, 1);
    chk(fifo_level == 0, "R11 level", fifo_level, 0);
    chk(fifo_low == 1'b1, "R11 fifo_low", fifo_low, 1);
    chk(tx_end == 1'b1, "R11 tx_end", tx_end, 1);
    chk(tx_irq == 1'b0, "R11 tx_irq", tx_irq, 0);
    chk(overflow == 1'b0, "R11 overflow", overflow, 0);

    // R4: clear ignored at level 0
    pulse_clr();
    chk(fifo_low == 1'b1, "R4 clear ignored", fifo_low, 1);

    // R5 enable gating
    tx_irq_en = 1'b1;
    @(negedge clk);
    chk(tx_irq == 1'b1, "R5 irq on", tx_irq, 1);
    tx_irq_en = 1'b0;
    @(negedge clk);
    chk(tx_irq == 1'b0, "R5 irq off", tx_irq, 0);

    // R1 internal clock burst
    rise_cnt = 0;
    put(8'hA5, 1);
    chk(tx_end == 1'b0, "R7 write clears end", tx_end, 0);
    put(8'h3C, 1);
    put(8'h35, 1);
    wait_idle();
    chk(rise_cnt == 24, "R2 rising edges", rise_cnt, 24);
    chk(last_rise - first_rise == 23 * 2 * HALF, "R1 no gap",
        last_rise - first_rise, 23 * 2 * HALF);
    chk(tx_end == 1'b1, "R6 end set", tx_end, 1);
    chk(txd == 1'b0, "R6 holds bit7", txd, 0);
    chk(sclk_out == 1'b1, "R8 parked high", sclk_out, 1);
    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);

    // R3/R4/R5/R9: external clock held, threshold 4
    ext_clk_sel = 1'b1;
    ext_clk_in = 1'b1;
    trig_sel = 2'd2;
    tx_irq_en = 1'b1;
    put(8'h11, 1); put(8'h22, 1); put(8'h33, 1);
    put(8'h44, 1); put(8'h55, 1); put(8'h66, 1);
    repeat (3) @(negedge clk);
    chk(fifo_level == 5, "R9 held clock keeps queue", fifo_level, 5);
    pulse_clr();
    chk(fifo_low == 1'b0, "R4 clear above level", fifo_low, 0);
    chk(tx_irq == 1'b0, "R5 irq follows low", tx_irq, 0);
    ext_pulses(8, 5);
    chk(fifo_level == 4, "R3 level after frame", fifo_level, 4);
    chk(fifo_low == 1'b1, "R3 low at threshold", fifo_low, 1);
    chk(tx_irq == 1'b1, "R5 irq raised", tx_irq, 1);
    ext_pulses(40, 4);
    repeat (6) @(negedge clk);
    chk(tx_end == 1'b1, "R9 ext end", tx_end, 1);
    chk(exp_q.size() == 0, "R9 ext frames", exp_q.size(), 0);

    // R10 overflow: 1 in shifter + DEPTH in queue, next dropped
    trig_sel = 2'd3;
    for (int i = 0; i < DEPTH + 1; i++) put(8'(8'h80 + i * 7), 1);
    chk(overflow == 1'b0, "R10 no overflow yet", overflow, 0);
    chk(fifo_level == DEPTH, "R10 full", fifo_level, DEPTH);
    put(8'hEE, 0);
    chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
    chk(fifo_level == DEPTH, "R10 level kept", fifo_level, DEPTH);
    ext_pulses((DEPTH + 1) * 8, 3);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R10 dropped byte absent", exp_q.size(), 0);
    chk(overflow == 1'b1, "R10 sticky", overflow, 1);
    chk(sclk_out == 1'b1, "R8 ext parked high", sclk_out, 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule